// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a circular list of transmit buffer descriptors kept in system memory. Each descriptor occupies 8 bytes. The block reads one descriptor at a time through a simple read port. When the descriptor is marked ready, it offers the buffer's address, its length and its end-of-frame and CRC flags to a downstream data mover over a valid/ready handshake. It then writes the status half-word back into memory with the ready bit cleared. The low status bits of that write-back are supplied by the downstream side at the handshake.

Software sets the ring start through a base write and starts processing with a kick. The engine goes idle, and drops its active flag, as soon as it reads a descriptor that is not ready. A kick that arrives while the engine is busy is held as a pending request. That request forces one more read of the current descriptor, so buffers that software has just handed over are never stranded. A completed buffer can raise a buffer event, and a completed end-of-frame buffer can also raise a frame event.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset, active, rd_req, buf_valid, wr_req, evt_buf and evt_frame are all low, and the current pointer equals the base, which is 0.
- R2: A kick while idle raises active on the next cycle and issues a read of the descriptor at the current pointer. A base write while idle also loads the current pointer.
- R3: Read data is laid out with length in bits 15:0, status in bits 31:16 and buffer address in bits 63:32. Status bit 15 is READY, 13 is WRAP, 12 requests an event, 11 marks end of frame and 10 requests CRC. buf_last carries status bit 11 and buf_crc carries status bit 10.
- R4: At most one descriptor read is outstanding. No rd_req is issued between a request and its rd_valid.
- R5: While buf_valid is high and buf_ready is low, buf_valid, buf_addr, buf_len and buf_last hold their values.
- R6: An accepted buffer is followed by exactly one write to descriptor address + 2. The written value has bit 15 = 0, bits 14:10 copied from the fetched status and bits 9:0 equal to dn_sts captured at the handshake. The pointer then moves to the base if WRAP was set, and to the pointer + 8 otherwise.
- R7: A fetched descriptor with READY clear, with no pending or simultaneous kick, produces no buffer, sends the engine idle and clears active.
- R8: A kick that arrives while the engine is busy, including in the same cycle as a not-ready fetch result, causes one more read of the current descriptor.
- R9: One cycle after a write-back is acknowledged, evt_buf pulses for one cycle if status bit 12 was set. evt_frame pulses alongside it if bits 12 and 11 were both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Ring start address write strobe |
| base_wdata | input | ADDR_W | Ring start address |
| kick_we | input | 1 | Kick (descriptor-active write) strobe |
| active | output | 1 | Engine running |
| rd_req | output | 1 | Descriptor read request, one cycle |
| rd_addr | output | ADDR_W | Descriptor read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Descriptor contents |
| buf_valid | output | 1 | Buffer offer valid |
| buf_ready | input | 1 | Downstream accepts the buffer |
| buf_addr | output | 32 | Buffer address |
| buf_len | output | 16 | Buffer length in bytes |
| buf_last | output | 1 | Buffer ends a frame |
| buf_crc | output | 1 | Append CRC request |
| dn_sts | input | 10 | Status bits for write-back, sampled at handshake |
| wr_req | output | 1 | Status write-back request, held until acknowledged |
| wr_addr | output | ADDR_W | Status half-word address |
| wr_data | output | 16 | Status half-word |
| wr_ack | input | 1 | Write-back complete |
| evt_buf | output | 1 | Buffer-done event pulse |
| evt_frame | output | 1 | Frame-done event pulse |

## Verification
A wrong pointer shows up within one descriptor. The next buffer offered, or the address of the next status write, differs from what the ring layout predicts, and a skipped wrap re-reads a descriptor that should have been passed. A pending-kick state that is lost leaves a ready descriptor unconsumed, so the scoreboard queue stays non-empty once active falls. That becomes visible a few cycles after the not-ready fetch. A corrupted held status appears in the written-back half-word, or as a missing or extra event pulse, on the cycle after the write acknowledge.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int DESC_BYTES = 8;
    localparam int DESC_W     = 64;
    localparam int LEN_W      = 16;
    localparam int STAT_W     = 16;
    localparam int BUFA_W     = 32;
    localparam int DN_W       = 10;
    localparam int LEN_LSB    = 0;
    localparam int STAT_LSB   = LEN_LSB + LEN_W;
    localparam int BUFA_LSB   = STAT_LSB + STAT_W;
    localparam int B_READY    = 15;
    localparam int B_WRAP     = 13;
    localparam int B_EVT      = 12;
    localparam int B_LAST     = 11;
    localparam int B_CRC      = 10;
    localparam int STAT_OFS   = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_OFFER,
        S_WBACK
    } seq_state_e;
endpackage

// File: rtl/txd_kick_latch.sv
module txd_kick_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic busy,
    input  logic consume,
    output logic pend
);
    typedef struct packed {
        logic pend;
    } kick_t;

    kick_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (consume) begin
            k_d.pend = 1'b0;
        end else if (kick && busy) begin
            k_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q <= '0;
        end else begin
            k_q <= k_d;
        end
    end

    assign pend = k_q.pend;
endmodule

// File: rtl/txd_evt.sv
module txd_evt
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [STAT_W-1:0] done_sts,
    output logic              evt_buf,
    output logic              evt_frame
);
    typedef struct packed {
        logic b;
        logic f;
    } evt_t;

    evt_t e_d, e_q;

    always_comb begin
        e_d.b = done && done_sts[B_EVT];
        e_d.f = done && done_sts[B_EVT] && done_sts[B_LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign evt_buf   = e_q.b;
    assign evt_frame = e_q.f;
endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              kick,
    input  logic              pend,
    output logic              consume,
    output logic              busy,
    output logic              active,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DESC_W-1:0] rd_data,
    output logic              buf_valid,
    input  logic              buf_ready,
    output logic [BUFA_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              buf_last,
    output logic              buf_crc,
    input  logic [DN_W-1:0]   dn_sts,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [STAT_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              done,
    output logic [STAT_W-1:0] done_sts
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] SOFS = ADDR_W'(STAT_OFS);
    localparam int CTRL_W = STAT_W - 1 - DN_W;

    typedef struct packed {
        seq_state_e        st;
        logic              act;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
        logic [LEN_W-1:0]  len;
        logic [STAT_W-1:0] sts;
        logic [BUFA_W-1:0] bufa;
        logic [DN_W-1:0]   dsts;
    } seq_t;

    seq_t s_d, s_q;
    logic [STAT_W-1:0] rd_sts;

    assign rd_sts = rd_data[STAT_LSB +: STAT_W];

    always_comb begin
        s_d     = s_q;
        consume = 1'b0;
        done    = 1'b0;
        if (base_we) begin
            s_d.base = base_wdata;
            if (s_q.st == S_IDLE) begin
                s_d.cur = base_wdata;
            end
        end
        unique case (s_q.st)
            S_IDLE: begin
                if (kick) begin
                    s_d.act = 1'b1;
                    s_d.st  = S_ISSUE;
                end
            end
            S_ISSUE: begin
                s_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (rd_valid) begin
                    s_d.len  = rd_data[LEN_LSB +: LEN_W];
                    s_d.sts  = rd_sts;
                    s_d.bufa = rd_data[BUFA_LSB +: BUFA_W];
                    if (rd_sts[B_READY]) begin
                        s_d.st = S_OFFER;
                    end else if (pend || kick) begin
                        consume = 1'b1;
                        s_d.st  = S_ISSUE;
                    end else begin
                        s_d.act = 1'b0;
                        s_d.st  = S_IDLE;
                    end
                end
            end
            S_OFFER: begin
                if (buf_ready) begin
                    s_d.dsts = dn_sts;
                    s_d.st   = S_WBACK;
                end
            end
            S_WBACK: begin
                if (wr_ack) begin
                    done   = 1'b1;
                    s_d.cur = s_q.sts[B_WRAP] ? s_q.base : (s_q.cur + STEP);
                    s_d.st = S_ISSUE;
                end
            end
            default: begin
                s_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != S_IDLE);
    assign active    = s_q.act;
    assign rd_req    = (s_q.st == S_ISSUE);
    assign rd_addr   = s_q.cur;
    assign buf_valid = (s_q.st == S_OFFER);
    assign buf_addr  = s_q.bufa;
    assign buf_len   = s_q.len;
    assign buf_last  = s_q.sts[B_LAST];
    assign buf_crc   = s_q.sts[B_CRC];
    assign wr_req    = (s_q.st == S_WBACK);
    assign wr_addr   = s_q.cur + SOFS;
    assign wr_data   = {1'b0, s_q.sts[STAT_W-2 -: CTRL_W], s_q.dsts};
    assign done_sts  = s_q.sts;
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              kick_we,
    output logic              active,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [63:0]       rd_data,
    output logic              buf_valid,
    input  logic              buf_ready,
    output logic [31:0]       buf_addr,
    output logic [15:0]       buf_len,
    output logic              buf_last,
    output logic              buf_crc,
    input  logic [9:0]        dn_sts,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    input  logic              wr_ack,
    output logic              evt_buf,
    output logic              evt_frame
);
    logic              pend;
    logic              consume;
    logic              busy;
    logic              done;
    logic [STAT_W-1:0] done_sts;

    txd_kick_latch u_kick (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick_we),
        .busy    (busy),
        .consume (consume),
        .pend    (pend)
    );

    txd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .kick       (kick_we),
        .pend       (pend),
        .consume    (consume),
        .busy       (busy),
        .active     (active),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .buf_valid  (buf_valid),
        .buf_ready  (buf_ready),
        .buf_addr   (buf_addr),
        .buf_len    (buf_len),
        .buf_last   (buf_last),
        .buf_crc    (buf_crc),
        .dn_sts     (dn_sts),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ack     (wr_ack),
        .done       (done),
        .done_sts   (done_sts)
    );

    txd_evt u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_sts  (done_sts),
        .evt_buf   (evt_buf),
        .evt_frame (evt_frame)
    );
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        kick_we,
    input logic        active,
    input logic        rd_req,
    input logic        rd_valid,
    input logic        buf_valid,
    input logic        buf_ready,
    input logic [31:0] buf_addr,
    input logic [15:0] buf_len,
    input logic        buf_last,
    input logic        wr_req,
    input logic        wr_ack,
    input logic        evt_buf,
    input logic        evt_frame
);
    logic rd_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy <= 1'b0;
        end else if (rd_req) begin
            rd_busy <= 1'b1;
        end else if (rd_valid) begin
            rd_busy <= 1'b0;
        end
    end

    p_kick_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kick_we |=> active);

    p_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !rd_busy);

    p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr)
                                       && $stable(buf_len) && $stable(buf_last)));

    p_wb_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && buf_ready) |=> wr_req);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!buf_valid && !wr_req && !rd_req));

    p_frame_needs_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |-> evt_buf);

    p_evt_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf |-> $past(wr_ack));
endmodule

bind txd_ring_walker txd_ring_walker_chk u_chk (.*);

// File: tb/txd_ring_walker_test.sv
module txd_ring_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        kick_we = 1'b0;
    logic        active;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        buf_valid;
    logic        buf_ready;
    logic [31:0] buf_addr;
    logic [15:0] buf_len;
    logic        buf_last;
    logic        buf_crc;
    logic [9:0]  dn_sts;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ack;
    logic        evt_buf;
    logic        evt_frame;

    always #10 clk = ~clk;

    txd_ring_walker uut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .kick_we(kick_we), .active(active), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .buf_valid(buf_valid),
        .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
        .buf_last(buf_last), .buf_crc(buf_crc), .dn_sts(dn_sts),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .evt_buf(evt_buf), .evt_frame(evt_frame)
    );

    int nchk = 0;
    int nerr = 0;
    int nbuf = 0;
    int nfrm = 0;
    int cyc = 0;
    bit rdy_mode = 1'b0;

    logic        host_we = 1'b0;
    logic [6:0]  host_idx = '0;
    logic [63:0] host_data = '0;
    logic [63:0] mem [128];

    assign dn_sts    = buf_len[9:0] ^ 10'h155;
    assign buf_ready = rdy_mode ? cyc[1] : 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            wr_ack   <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= mem[rd_addr[9:3]];
            wr_ack <= wr_req && !wr_ack;
            if (host_we) mem[host_idx] <= host_data;
            if (wr_req && !wr_ack) mem[wr_addr[9:3]][31:16] <= wr_data;
        end
    end

    typedef struct packed {
        logic [31:0] a;
        logic [15:0] l;
        logic        last;
        logic        crc;
    } item_t;

    item_t exp_q[$];
    item_t held;
    bit    hold = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_buf) nbuf++;
            if (evt_frame) nfrm++;
            if (buf_valid) begin
                item_t got;
                got = '{a: buf_addr, l: buf_len, last: buf_last, crc: buf_crc};
                if (hold) chk(got == held, "R5 held offer", 64'(got), 64'(held));
                if (buf_ready) begin
                    hold = 1'b0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected buffer", 64'(got), 64'h0);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        chk(got == e, "R3 buffer fields", 64'(got), 64'(e));
                    end
                end else begin
                    hold = 1'b1;
                    held = got;
                end
            end
        end
    end

    function automatic logic [15:0] wb_val(input logic [15:0] sts, input logic [15:0] len);
        return {1'b0, sts[14:10], len[9:0] ^ 10'h155};
    endfunction

    task automatic put(input int idx, input logic [15:0] sts, input logic [15:0] len,
                       input logic [31:0] bufa, input bit expect_it);
        @(negedge clk);
        host_we   = 1'b1;
        host_idx  = 7'(idx);
        host_data = {bufa, sts, len};
        @(negedge clk);
        host_we = 1'b0;
        if (expect_it) exp_q.push_back('{a: bufa, l: len, last: sts[11], crc: sts[10]});
    endtask

    task automatic set_base(input logic [31:0] a);
        @(negedge clk);
        base_we = 1'b1;
        base_wdata = a;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic kick_pulse();
        @(negedge clk);
        kick_we = 1'b1;
        @(negedge clk);
        kick_we = 1'b0;
        chk(active == 1'b1, "R2 active after kick", 64'(active), 64'h1);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (active && n < 2000);
        repeat (3) @(negedge clk);
        chk(active == 1'b0, {tag, " R7 idle"}, 64'(active), 64'h0);
        chk(exp_q.size() == 0, {tag, " R8 all buffers consumed"}, 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!active && !rd_req && !buf_valid && !wr_req && !evt_buf && !evt_frame,
            "R1 reset outputs", {58'h0, active, rd_req, buf_valid, wr_req, evt_buf, evt_frame}, 64'h0);
        chk(rd_addr == 32'h0, "R1 reset pointer", 64'(rd_addr), 64'h0);
        rst_n = 1'b1;

        // R3 R6 R9: three ready descriptors, the third wraps, the fourth must be skipped
        set_base(32'h100);
        put(32, 16'h9000, 16'd60,  32'hA000_0000, 1);
        put(33, 16'h9800, 16'd100, 32'hA000_1000, 1);
        put(34, 16'hAC00, 16'd200, 32'hA000_2000, 1);
        put(35, 16'h8800, 16'd300, 32'hA000_3000, 0);
        kick_pulse();
        wait_idle("ring1");
        chk(mem[32][31:16] == wb_val(16'h9000, 16'd60), "R6 write-back first",
            64'(mem[32][31:16]), 64'(wb_val(16'h9000, 16'd60)));
        chk(mem[34][31:16] == wb_val(16'hAC00, 16'd200), "R6 write-back wrap desc",
            64'(mem[34][31:16]), 64'(wb_val(16'hAC00, 16'd200)));
        chk(mem[35][31:16] == 16'h8800, "R6 wrap skips next slot", 64'(mem[35][31:16]), 64'h8800);
        chk(nbuf == 2, "R9 buffer events", 64'(nbuf), 64'd2);
        chk(nfrm == 1, "R9 frame events", 64'(nfrm), 64'd1);

        // R5: back-pressure from the downstream side
        rdy_mode = 1'b1;
        put(32, 16'h9800, 16'd64, 32'hB000_0000, 1);
        put(33, 16'hA000, 16'd70, 32'hB000_1000, 1);
        kick_pulse();
        wait_idle("stall");
        rdy_mode = 1'b0;
        chk(mem[33][31:16] == wb_val(16'hA000, 16'd70), "R6 write-back under stall",
            64'(mem[33][31:16]), 64'(wb_val(16'hA000, 16'd70)));
        chk(nbuf == 3 && nfrm == 2, "R9 event totals", 64'({nbuf[15:0], nfrm[15:0]}), 64'h0003_0002);

        // R8 case A: kick in the same cycle as the not-ready result
        kick_pulse();
        chk(rd_req && rd_addr == 32'h100, "R2 read at current pointer", 64'(rd_addr), 64'h100);
        @(negedge clk);
        chk(rd_valid == 1'b1, "R8 read returned", 64'(rd_valid), 64'h1);
        host_we   = 1'b1;
        host_idx  = 7'd32;
        host_data = {32'hC000_0000, 16'hA800, 16'd80};
        exp_q.push_back('{a: 32'hC000_0000, l: 16'd80, last: 1'b1, crc: 1'b0});
        kick_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        kick_we = 1'b0;
        wait_idle("coincident");

        // R8 case B: kick while the read is in flight
        kick_pulse();
        chk(rd_req == 1'b1, "R8 read issued", 64'(rd_req), 64'h1);
        kick_we = 1'b1;
        @(negedge clk);
        kick_we   = 1'b0;
        host_we   = 1'b1;
        host_idx  = 7'd32;
        host_data = {32'hC100_0000, 16'hAC00, 16'd90};
        exp_q.push_back('{a: 32'hC100_0000, l: 16'd90, last: 1'b1, crc: 1'b1});
        @(negedge clk);
        host_we = 1'b0;
        wait_idle("inflight");

        // R2: new base while idle redirects the pointer
        set_base(32'h200);
        put(64, 16'hB800, 16'd90, 32'hD000_0000, 1);
        kick_pulse();
        wait_idle("rebase");
        chk(mem[64][31:16] == wb_val(16'hB800, 16'd90), "R2 R6 write-back at new base",
            64'(mem[64][31:16]), 64'(wb_val(16'hB800, 16'd90)));
        chk(mem[32][31] == 1'b0, "R2 old ring untouched", 64'(mem[32][31]), 64'h0);
        chk(nbuf == 4 && nfrm == 3, "R9 event totals end", 64'({nbuf[15:0], nfrm[15:0]}), 64'h0004_0003);

        // R7: kick onto a not-ready descriptor yields nothing
        kick_pulse();
        wait_idle("empty");
        chk(nbuf == 4, "R7 no event on empty ring", 64'(nbuf), 64'd4);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule